// File: doc/BRIEF.md
# Delayed-Commit Line Memory with Sideband Writer

This block is a small word-addressed store that holds its contents as lines of four 32-bit words. Several requesters share one write port. A normal requester that finds the port free takes ownership of it. It then has to present the same request every cycle until a programmable countdown expires, and only then does its word commit. Each cycle the port answers combinationally with OK or WAIT.

A dedicated sideband requester skips the countdown. Its word is stored at the clock edge that ends the cycle in which it is presented, and it gets OK in that same cycle. Like any completed write, a sideband write leaves the port unowned. An owner that was interrupted must therefore claim the port again and sit through the full delay a second time. A separate view port returns one whole line combinationally, for inspection.

Top module: `lined_write_mem`

## Requirements
- R1: A synchronous reset clears every word to zero and leaves the port unowned.
- R2: A normal requester (ID 1, 2 or 3) that presents a valid request to an unowned port takes ownership and captures `cfg_delay` as D in that cycle. Its first D request cycles return WAIT, and request cycle D+1 returns OK with the word written at that clock edge. Ownership then returns to unowned.
- R3: While an owner is waiting, memory is unchanged, and cycles in which it does not present a request leave its remaining count as it was.
- R4: A valid request from a normal requester that is not the owner, while the port is owned, returns WAIT and changes neither memory nor the owner's countdown.
- R5: A sideband request (ID 4) returns OK in the cycle it is presented and writes its word at that clock edge, whatever the delay setting and whoever owns the port.
- R6: Any completed write, sideband writes included, leaves the port unowned. A previous owner therefore restarts with a full delay.
- R7: The delay is sampled only in the cycle ownership is taken, so later changes to `cfg_delay` do not shorten or lengthen a wait that is already running.
- R8: With a captured delay of 0, the claiming request itself returns OK and writes in that cycle.
- R9: An address whose line index is at or beyond the number of lines returns OK when it completes but writes nothing, and no stored line changes.
- R10: With `req_valid` low, or with a valid request carrying an ID that is not a requester (0, 5, 6 or 7), the response is WAIT (0) and no state changes.
- R11: The line index is address divided by four and the word index is address modulo four. `view_data` carries word k of line `view_line` in bits [32k+31:32k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is presented this cycle |
| req_id | input | 3 | Requester: 1, 2, 3 normal; 4 sideband; others are not requesters |
| req_addr | input | ADDR_W (6) | Word address |
| req_data | input | WORD_W (32) | Signed word to write |
| cfg_delay | input | 4 | Wait cycles captured when ownership is taken |
| rsp_ok | output | 1 | 1 = OK, 0 = WAIT, combinational |
| view_line | input | IDX_W (3) | Line selected for the view port |
| view_data | output | 4*WORD_W (128) | The four words of the selected line |

## Verification
The assertions take for granted that inputs are stable for the whole cycle in which they are sampled. They also assume that an owner presents the same ID on every cycle it wants serviced. The hold-memory property only compares the view output when `view_line` did not move. To stay within these limits, the stimulus changes every input only at the falling edge and keeps each requester's ID fixed across its sequence. It picks view lines explicitly on cycles with no request, so that every memory comparison falls on a quiet port.

// File: rtl/lined_write_mem.sv
module lined_write_mem #(
  parameter int WORD_W    = 32,
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 6,
  parameter int DELAY_W   = 4,
  localparam int LINE_W   = ADDR_W - 2,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_valid,
  input  logic [2:0]               req_id,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic signed [WORD_W-1:0] req_data,
  input  logic [DELAY_W-1:0]       cfg_delay,
  output logic                     rsp_ok,
  input  logic [IDX_W-1:0]         view_line,
  output logic [4*WORD_W-1:0]      view_data
);
  localparam logic [2:0] ID_NONE = 3'd0;
  localparam logic [2:0] ID_SIDE = 3'd4;

  logic [WORD_W-1:0]  mem [NUM_LINES][4];
  logic [2:0]         owner_q;
  logic [DELAY_W-1:0] cnt_q;

  logic [LINE_W-1:0]  line;
  logic [1:0]         word;
  logic               in_range, normal, side, claim, is_owner, serving, commit, done;
  logic [DELAY_W-1:0] cnt_eff;

  assign line     = req_addr[ADDR_W-1:2];
  assign word     = req_addr[1:0];
  assign in_range = {{(32-LINE_W){1'b0}}, line} < NUM_LINES;

  assign normal   = req_valid && req_id != ID_NONE && req_id < ID_SIDE;
  assign side     = req_valid && req_id == ID_SIDE;
  assign claim    = normal && owner_q == ID_NONE;
  assign is_owner = normal && owner_q == req_id;
  assign serving  = claim || is_owner;
  assign cnt_eff  = claim ? cfg_delay : cnt_q;
  assign commit   = serving && cnt_eff == '0;
  assign done     = side || commit;
  assign rsp_ok   = done;

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_q <= ID_NONE;
      cnt_q   <= '0;
      for (int l = 0; l < NUM_LINES; l++)
        for (int w = 0; w < 4; w++)
          mem[l][w] <= '0;
    end else begin
      if (done) owner_q <= ID_NONE;
      else if (claim) owner_q <= req_id;
      if (serving && cnt_eff != '0) cnt_q <= cnt_eff - 1'b1;
      if (done && in_range) mem[line[IDX_W-1:0]][word] <= req_data;
    end
  end

  for (genvar k = 0; k < 4; k++) begin : g_view
    assign view_data[k*WORD_W +: WORD_W] = mem[view_line][k];
  end
endmodule

// File: rtl/lined_write_mem_chk.sv
module lined_write_mem_chk #(
  parameter int WORD_W    = 32,
  parameter int NUM_LINES = 8,
  parameter int DELAY_W   = 4,
  localparam int IDX_W    = $clog2(NUM_LINES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_valid,
  input logic [2:0]           req_id,
  input logic                 rsp_ok,
  input logic [2:0]           owner,
  input logic [DELAY_W-1:0]   cnt,
  input logic [IDX_W-1:0]     view_line,
  input logic [4*WORD_W-1:0]  view_data
);
  // R5
  side_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_id == 3'd4) |-> rsp_ok);

  // R10
  idle_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_id == 3'd0 || req_id > 3'd4) |-> !rsp_ok);

  // R4
  stranger_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_id != 3'd0 && req_id < 3'd4 && owner != 3'd0 && owner != req_id)
      |-> !rsp_ok);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_ok |=> owner == 3'd0);

  // R2
  countdown_chk: assert property (@(posedge clk) disable iff (rst)
    (owner != 3'd0 && req_valid && req_id == owner && !rsp_ok) |=> cnt == $past(cnt) - 1'b1);

  // R3
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rsp_ok |=> ($stable(view_line) -> $stable(view_data)));
endmodule

bind lined_write_mem lined_write_mem_chk #(
  .WORD_W(WORD_W), .NUM_LINES(NUM_LINES), .DELAY_W(DELAY_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .rsp_ok(rsp_ok),
  .owner(owner_q), .cnt(cnt_q), .view_line(view_line), .view_data(view_data)
);

// File: tb/sim_lined_write_mem.sv
module sim_lined_write_mem;
  localparam int CLK_P = 10;
  localparam int W = 32;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_id = '0;
  logic [5:0] req_addr = '0;
  logic signed [W-1:0] req_data = '0;
  logic [3:0] cfg_delay = '0;
  logic rsp_ok;
  logic [2:0] view_line = '0;
  logic [4*W-1:0] view_data;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;
  bit exp_q[$];
  string tag_q[$];
  logic [W-1:0] mdl [NL][4];

  always #(CLK_P/2) clk = ~clk;

  lined_write_mem u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_id(req_id), .req_addr(req_addr),
    .req_data(req_data), .cfg_delay(cfg_delay), .rsp_ok(rsp_ok),
    .view_line(view_line), .view_data(view_data)
  );

  task automatic drive(input bit v, input logic [2:0] id, input logic [5:0] a,
                       input logic [W-1:0] d, input logic [3:0] dl,
                       input bit exp_ok, input bit exp_wr, input string tag);
    @(negedge clk);
    req_valid = v; req_id = id; req_addr = a; req_data = d; cfg_delay = dl;
    exp_q.push_back(exp_ok);
    tag_q.push_back(tag);
    if (exp_wr && a[5:2] < NL) mdl[a[4:2]][a[1:0]] = d;
  endtask

  task automatic chk_line(input int l, input string tag);
    logic [4*W-1:0] e;
    @(negedge clk);
    req_valid = 1'b0;
    exp_q.push_back(1'b0);
    tag_q.push_back("R10 quiet");
    view_line = l[2:0];
    for (int k = 0; k < 4; k++) e[k*W +: W] = mdl[l][k];
    #1;
    compared++;
    if (view_data !== e) begin
      mismatched++;
      $display("FAIL %s line %0d: actual %h expected %h", tag, l, view_data, e);
    end
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        compared++;
        if (rsp_ok !== e) begin
          mismatched++;
          $display("FAIL %s rsp: actual %b expected %b", t, rsp_ok, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_P * 5000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin : stim
    for (int l = 0; l < NL; l++)
      for (int k = 0; k < 4; k++) mdl[l][k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset clears all lines
    for (int l = 0; l < NL; l++) chk_line(l, "R1 reset");

    // R10 no request / non-requester IDs
    drive(0, 3'd3, 6'd0, 32'h1, 4'd0, 0, 0, "R10 invalid");
    drive(1, 3'd0, 6'd0, 32'h2, 4'd0, 0, 0, "R10 id0");
    drive(1, 3'd5, 6'd0, 32'h3, 4'd0, 0, 0, "R10 id5");
    drive(1, 3'd7, 6'd0, 32'h4, 4'd0, 0, 0, "R10 id7");
    chk_line(0, "R10 no write");

    // R2 R3 delay 3: three waits then commit; quiet cycle keeps the count
    drive(1, 3'd3, 6'd0, 32'h11223344, 4'd3, 0, 0, "R2 wait1");
    drive(1, 3'd3, 6'd0, 32'h11223344, 4'd3, 0, 0, "R2 wait2");
    chk_line(0, "R3 unchanged during wait");
    drive(1, 3'd3, 6'd0, 32'h11223344, 4'd3, 0, 0, "R2 wait3");
    drive(1, 3'd3, 6'd0, 32'h11223344, 4'd3, 1, 1, "R2 commit");
    chk_line(0, "R2 written");

    // R11 address 13 -> line 3 word 1
    drive(1, 3'd4, 6'd13, 32'hCAFE0013, 4'd9, 1, 1, "R11 side write");
    chk_line(3, "R11 mapping");

    // R5 R6 sideband interrupts an owner, which restarts the full delay
    drive(1, 3'd3, 6'd2, 32'hA5A50002, 4'd3, 0, 0, "R6 own wait1");
    drive(1, 3'd3, 6'd2, 32'hA5A50002, 4'd3, 0, 0, "R6 own wait2");
    drive(1, 3'd4, 6'd1, 32'h55667788, 4'd3, 1, 1, "R5 side immediate");
    drive(1, 3'd3, 6'd2, 32'hA5A50002, 4'd3, 0, 0, "R6 reclaim wait1");
    drive(1, 3'd3, 6'd2, 32'hA5A50002, 4'd3, 0, 0, "R6 reclaim wait2");
    drive(1, 3'd3, 6'd2, 32'hA5A50002, 4'd3, 0, 0, "R6 reclaim wait3");
    drive(1, 3'd3, 6'd2, 32'hA5A50002, 4'd3, 1, 1, "R6 reclaim commit");
    chk_line(0, "R5 R6 line");

    // R4 another normal requester is refused while the port is owned
    drive(1, 3'd1, 6'd5, 32'h0F0F0005, 4'd2, 0, 0, "R4 owner wait1");
    drive(1, 3'd2, 6'd6, 32'hDEAD0006, 4'd0, 0, 0, "R4 stranger");
    drive(1, 3'd1, 6'd5, 32'h0F0F0005, 4'd2, 0, 0, "R4 owner wait2");
    drive(1, 3'd2, 6'd6, 32'hDEAD0006, 4'd0, 0, 0, "R4 stranger");
    drive(1, 3'd1, 6'd5, 32'h0F0F0005, 4'd2, 1, 1, "R4 owner commit");
    chk_line(1, "R4 stranger wrote nothing");

    // R8 zero delay commits on the claiming cycle
    drive(1, 3'd2, 6'd6, 32'hBEEF0006, 4'd0, 1, 1, "R8 zero delay");
    chk_line(1, "R8 written");

    // R7 delay captured at claim; raising cfg_delay later has no effect
    drive(1, 3'd3, 6'd7, 32'h77770007, 4'd1, 0, 0, "R7 wait");
    drive(1, 3'd3, 6'd7, 32'h77770007, 4'd15, 1, 1, "R7 commit despite new delay");
    chk_line(1, "R7 written");

    // R9 out-of-range lines: OK, no write, no aliasing
    drive(1, 3'd4, 6'd32, 32'hBAD00020, 4'd0, 1, 0, "R9 side oor");
    drive(1, 3'd1, 6'd63, 32'hBAD0003F, 4'd0, 1, 0, "R9 owner oor");
    chk_line(0, "R9 line0 intact");
    chk_line(7, "R9 line7 intact");

    // R11 last word of last line
    drive(1, 3'd4, 6'd31, 32'h31313131, 4'd5, 1, 1, "R11 side last word");
    chk_line(7, "R11 last word");

    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule